// File: doc/BRIEF.md
# Stored Register Write Cycle Sequencer

This block sequences writes into a small bank of emulated non-volatile 8-bit data registers. Each wiper channel has several of these registers. A host command does not write storage at once. A host data write, a copy of one channel's wiper value, or a copy of every channel's wiper value only arms a pending write while the device is selected. The write happens when chip select (active low) returns high after the complete command. A busy period follows, and a timer counts it in tick-enable pulses. For that whole period the block reports the write-in-progress status.

Write protect (active low) blocks stored writes. When it falls during a selected sequence, it discards the pending write. Once a write cycle has started, write protect has no influence on it. A partial trailing bit cancels the pending write, and so does any command that arrives while the block is busy. The block reports standby whenever chip select is high and no write cycle is running. It drives a write port into the storage array: one write-enable bit per channel, a shared register index, and one data lane per channel.

Top module: `sr_write_seq`

## Requirements
- R1: The storage write port (`st_we`) pulses for exactly one clock, and only in the cycle that follows the first clock edge at which `cs_n` is seen high after a low period with a pending write. A request presented while `cs_n` is high arms nothing.
- R2: While `wp_n` is low, a complete command arms no pending write, so raising `cs_n` produces no write and no busy period.
- R3: A low level on `wp_n` while `cs_n` is low cancels an already armed write.
- R4: After a write cycle has started, driving `wp_n` low changes neither the issued write nor the length of the busy period.
- R5: `busy` (write in progress) rises together with the write pulse. It stays high until exactly `BUSY_TICKS` clock edges with `tick_en` high have passed, and without ticks it stays high indefinitely.
- R6: Commands completed while `busy` is high are ignored: they produce no write and do not restart or lengthen the busy period.
- R7: `standby` is high exactly when `cs_n` is high and `busy` is low.
- R8: `req_kind`=1 (single transfer) writes the wiper value of channel `req_chan` as it was when the command was received. The value comes from lane `req_chan` of `wiper_flat`, bits [8*ch+7:8*ch]. It goes to register `req_idx` of that channel only.
- R9: `req_kind`=2 (global transfer) writes every channel's own wiper value into that channel's register `req_idx`. All channels are written in the same write pulse, followed by a single busy period.
- R10: A serial bit reported on `extra_bit` after arming, while selected, discards the pending write.
- R11: After reset, `busy` is low, `st_we` is zero and no write is pending.
- R12: `req_kind`=0 (host data write) writes `req_data` to register `req_idx` of channel `req_chan`. It sets only that channel's bit of `st_we`, and the data appears on lane `req_chan` of `st_data`.
- R13: `req_kind`=3 is reserved and arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write protect, active low |
| tick_en | input | 1 | Timebase pulse for the busy timer |
| req_valid | input | 1 | One-cycle pulse: a complete stored-write command was received |
| req_kind | input | 2 | 0 data write, 1 single transfer, 2 global transfer, 3 reserved |
| req_chan | input | CW | Target channel for kinds 0 and 1 |
| req_idx | input | IW | Target data register index |
| req_data | input | DW | Host data byte for kind 0 |
| wiper_flat | input | NCH*DW | Current wiper values, lane per channel |
| extra_bit | input | 1 | A serial bit arrived after the armed command |
| st_we | output | NCH | Storage write enable, one bit per channel |
| st_idx | output | IW | Storage register index |
| st_data | output | NCH*DW | Storage write data, lane per channel |
| busy | output | 1 | Write in progress |
| standby | output | 1 | Deselected and idle |

## Verification
The bench looks for the write appearing too early. A design that writes on the last data bit rather than on the rising chip select would pulse `st_we` while still selected. It probes the busy length one tick short and one tick at the end, which catches a timer that is off by one. Write protect is dropped both before the commit edge, where a correct design must lose the write, and after it, where a wrong design would cut the cycle short. Commands issued inside the busy window and partial trailing bits must leave the port silent. A global transfer must write both lanes in one pulse, not one lane or two pulses.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
   typedef enum logic [1:0] {
      KIND_DATA   = 2'd0,
      KIND_XFER   = 2'd1,
      KIND_GLOBAL = 2'd2,
      KIND_RSVD   = 2'd3
   } sr_kind_e;
endpackage

// File: rtl/sr_cs_edge.sv
module sr_cs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic cs_rise
);
   logic cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b1;
      else        cs_q <= cs_n;
   end

   // deselect edge: high now, low one cycle ago
   assign cs_rise = cs_n && !cs_q;
endmodule

// File: rtl/sr_pend.sv
module sr_pend
   import sr_seq_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int NREG = 4,
   parameter int DW   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  wp_n,
   input  logic                  busy,
   input  logic                  cs_rise,
   input  logic                  req_valid,
   input  sr_kind_e              req_kind,
   input  logic [$clog2(NCH)-1:0]  req_chan,
   input  logic [$clog2(NREG)-1:0] req_idx,
   input  logic [DW-1:0]         req_data,
   input  logic [NCH*DW-1:0]     wiper_flat,
   input  logic                  extra_bit,
   output logic                  pend_v,
   output logic [NCH-1:0]        pend_mask,
   output logic [$clog2(NREG)-1:0] pend_idx,
   output logic [NCH*DW-1:0]     pend_data
);
   localparam int CW = $clog2(NCH);
   localparam int IW = $clog2(NREG);

   logic              arm;
   logic              drop;
   logic [NCH-1:0]    nxt_mask;
   logic [NCH*DW-1:0] nxt_data;

   assign arm  = req_valid && !cs_n && !busy && wp_n && (req_kind != KIND_RSVD);
   assign drop = cs_rise || (!cs_n && (extra_bit || !wp_n));

   for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
      assign nxt_mask[ch] = (req_kind == KIND_GLOBAL) || (req_chan == CW'(ch));
      assign nxt_data[ch*DW +: DW] = (req_kind == KIND_DATA) ? req_data
                                                             : wiper_flat[ch*DW +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_mask <= '0;
         pend_idx  <= '0;
         pend_data <= '0;
      end else if (arm) begin
         pend_v    <= 1'b1;
         pend_mask <= nxt_mask;
         pend_idx  <= IW'(req_idx);
         pend_data <= nxt_data;
      end else if (drop) begin
         pend_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
   parameter int BUSY_TICKS = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick_en,
   output logic busy
);
   localparam int TW = $clog2(BUSY_TICKS + 1);

   logic [TW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (start) begin
         busy <= 1'b1;
         left <= TW'(BUSY_TICKS);
      end else if (busy && tick_en) begin
         if (left == TW'(1)) begin
            busy <= 1'b0;
            left <= '0;
         end else begin
            left <= left - TW'(1);
         end
      end
   end
endmodule

// File: rtl/sr_commit.sv
module sr_commit #(
   parameter int NCH  = 2,
   parameter int NREG = 4,
   parameter int DW   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [NCH-1:0]          pend_mask,
   input  logic [$clog2(NREG)-1:0] pend_idx,
   input  logic [NCH*DW-1:0]       pend_data,
   output logic [NCH-1:0]          st_we,
   output logic [$clog2(NREG)-1:0] st_idx,
   output logic [NCH*DW-1:0]       st_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_we   <= '0;
         st_idx  <= '0;
         st_data <= '0;
      end else begin
         st_we <= start ? pend_mask : '0;
         if (start) begin
            st_idx  <= pend_idx;
            st_data <= pend_data;
         end
      end
   end
endmodule

// File: rtl/sr_write_seq.sv
module sr_write_seq
   import sr_seq_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int NREG       = 4,
   parameter int DW         = 8,
   parameter int BUSY_TICKS = 5000,
   localparam int CW        = $clog2(NCH),
   localparam int IW        = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              tick_en,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [CW-1:0]     req_chan,
   input  logic [IW-1:0]     req_idx,
   input  logic [DW-1:0]     req_data,
   input  logic [NCH*DW-1:0] wiper_flat,
   input  logic              extra_bit,
   output logic [NCH-1:0]    st_we,
   output logic [IW-1:0]     st_idx,
   output logic [NCH*DW-1:0] st_data,
   output logic              busy,
   output logic              standby
);
   initial begin
      assert (NCH >= 2)        else $fatal(1, "NCH must be at least 2");
      assert (NREG >= 2)       else $fatal(1, "NREG must be at least 2");
      assert (DW >= 1)         else $fatal(1, "DW must be positive");
      assert (BUSY_TICKS >= 1) else $fatal(1, "BUSY_TICKS must be positive");
   end

   logic              cs_rise;
   logic              pend_v;
   logic [NCH-1:0]    pend_mask;
   logic [IW-1:0]     pend_idx;
   logic [NCH*DW-1:0] pend_data;
   logic              start;

   sr_cs_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .cs_rise (cs_rise)
   );

   sr_pend #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .wp_n       (wp_n),
      .busy       (busy),
      .cs_rise    (cs_rise),
      .req_valid  (req_valid),
      .req_kind   (sr_kind_e'(req_kind)),
      .req_chan   (req_chan),
      .req_idx    (req_idx),
      .req_data   (req_data),
      .wiper_flat (wiper_flat),
      .extra_bit  (extra_bit),
      .pend_v     (pend_v),
      .pend_mask  (pend_mask),
      .pend_idx   (pend_idx),
      .pend_data  (pend_data)
   );

   assign start = cs_rise && pend_v && !busy;

   sr_busy_timer #(.BUSY_TICKS(BUSY_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tick_en (tick_en),
      .busy    (busy)
   );

   sr_commit #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .pend_mask (pend_mask),
      .pend_idx  (pend_idx),
      .pend_data (pend_data),
      .st_we     (st_we),
      .st_idx    (st_idx),
      .st_data   (st_data)
   );

   assign standby = cs_n && !busy;
endmodule

// File: rtl/sr_write_seq_chk.sv
module sr_write_seq_chk #(
   parameter int NCH        = 2,
   parameter int BUSY_TICKS = 5000
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cs_n,
   input logic           tick_en,
   input logic [NCH-1:0] st_we,
   input logic           busy,
   input logic           standby
);
   localparam int TW = $clog2(BUSY_TICKS + 1) + 1;

   logic [TW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              seen <= '0;
      else if (!busy)          seen <= '0;
      else if (tick_en)        seen <= seen + TW'(1);
   end

   assert_commit_on_cs_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_we) |-> ($past(cs_n) && !$past(cs_n, 2)));

   assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_we) |=> (st_we == '0));

   assert_write_opens_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_we) |-> $rose(busy));

   assert_busy_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_en) |=> busy);

   assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (seen == TW'(BUSY_TICKS)));

   assert_standby_off_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !standby);

   assert_standby_off_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !standby);
endmodule

bind sr_write_seq sr_write_seq_chk #(.NCH(NCH), .BUSY_TICKS(BUSY_TICKS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .tick_en (tick_en),
   .st_we   (st_we),
   .busy    (busy),
   .standby (standby)
);

// File: tb/sim_sr_write_seq.sv
`timescale 1ns/1ps
module sim_sr_write_seq;
   localparam int NCH = 2;
   localparam int NREG = 4;
   localparam int DW = 8;
   localparam int BT = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, cs_n, wp_n, tick_en, req_valid, extra_bit;
   logic [1:0]  req_kind;
   logic [0:0]  req_chan;
   logic [1:0]  req_idx;
   logic [7:0]  req_data;
   logic [15:0] wiper_flat;
   logic [1:0]  st_we;
   logic [1:0]  st_idx;
   logic [15:0] st_data;
   logic        busy, standby;

   sr_write_seq #(.NCH(NCH), .NREG(NREG), .DW(DW), .BUSY_TICKS(BT)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .tick_en(tick_en),
      .req_valid(req_valid), .req_kind(req_kind), .req_chan(req_chan),
      .req_idx(req_idx), .req_data(req_data), .wiper_flat(wiper_flat),
      .extra_bit(extra_bit), .st_we(st_we), .st_idx(st_idx), .st_data(st_data),
      .busy(busy), .standby(standby)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sel();
      cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic desel();
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic arm(input logic [1:0] k, input logic ch, input logic [1:0] idx,
                      input logic [7:0] d);
      req_kind = k; req_chan = ch; req_idx = idx; req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic tick1();
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < BT + 2; i++) if (busy) tick1();
   endtask

   task automatic t_reset();
      chk("R11 busy after reset", busy, 0);
      chk("R11 st_we after reset", st_we, 0);
      chk("R7 standby idle", standby, 1);
   endtask

   task automatic t_data_write();
      sel();
      arm(2'd0, 1'b1, 2'd2, 8'hA5);
      @(negedge clk);
      chk("R1 no write while selected", st_we, 0);
      chk("R7 standby while selected", standby, 0);
      desel();
      chk("R12 we mask", st_we, 2'b10);
      chk("R12 index", st_idx, 2);
      chk("R12 lane1 data", st_data[15:8], 8'hA5);
      chk("R5 busy rises with write", busy, 1);
      chk("R7 standby while busy", standby, 0);
      @(negedge clk);
      chk("R1 single pulse", st_we, 0);
      repeat (3) @(negedge clk);
      chk("R5 busy holds without ticks", busy, 1);
      for (int i = 0; i < BT - 1; i++) tick1();
      chk("R5 busy one tick short", busy, 1);
      tick1();
      chk("R5 busy ends after BUSY_TICKS", busy, 0);
      chk("R7 standby after busy", standby, 1);
   endtask

   task automatic t_unselected_req();
      arm(2'd0, 1'b0, 2'd1, 8'h42);
      sel();
      desel();
      chk("R1 request while deselected ignored", st_we, 0);
      chk("R1 no busy from deselected request", busy, 0);
   endtask

   task automatic t_single_xfer();
      wiper_flat = {8'h3C, 8'h81};
      sel();
      arm(2'd1, 1'b0, 2'd3, 8'hFF);
      wiper_flat = {8'hEE, 8'hEE};
      desel();
      chk("R8 we mask", st_we, 2'b01);
      chk("R8 index", st_idx, 3);
      chk("R8 captured wiper", st_data[7:0], 8'h81);
      drain();
   endtask

   task automatic t_global_xfer();
      wiper_flat = {8'h5A, 8'hC3};
      sel();
      arm(2'd2, 1'b0, 2'd1, 8'h00);
      desel();
      chk("R9 both lanes enabled", st_we, 2'b11);
      chk("R9 index", st_idx, 1);
      chk("R9 data both lanes", st_data, 16'h5AC3);
      @(negedge clk);
      chk("R9 one write pulse", st_we, 0);
      for (int i = 0; i < BT; i++) tick1();
      chk("R9 single busy period", busy, 0);
   endtask

   task automatic t_wp_block();
      wp_n = 1'b0;
      sel();
      arm(2'd0, 1'b0, 2'd0, 8'h11);
      desel();
      chk("R2 no write when protected", st_we, 0);
      chk("R2 no busy when protected", busy, 0);
      wp_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_wp_cancel();
      sel();
      arm(2'd0, 1'b0, 2'd1, 8'h22);
      wp_n = 1'b0;
      @(negedge clk);
      wp_n = 1'b1;
      @(negedge clk);
      desel();
      chk("R3 cancelled write", st_we, 0);
      chk("R3 no busy", busy, 0);
   endtask

   task automatic t_wp_after_commit();
      sel();
      arm(2'd0, 1'b1, 2'd0, 8'h77);
      desel();
      chk("R4 write issued", st_we, 2'b10);
      chk("R4 data", st_data[15:8], 8'h77);
      wp_n = 1'b0;
      for (int i = 0; i < BT - 1; i++) tick1();
      chk("R4 busy unaffected by protect", busy, 1);
      tick1();
      chk("R4 busy ends on schedule", busy, 0);
      wp_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      sel();
      arm(2'd0, 1'b0, 2'd2, 8'h10);
      desel();
      tick1();
      sel();
      arm(2'd0, 1'b1, 2'd3, 8'h20);
      desel();
      chk("R6 no write while busy", st_we, 0);
      chk("R6 still busy", busy, 1);
      chk("R7 no standby while busy", standby, 0);
      for (int i = 0; i < BT - 2; i++) tick1();
      chk("R6 period not restarted", busy, 1);
      tick1();
      chk("R6 period not lengthened", busy, 0);
      sel();
      arm(2'd0, 1'b1, 2'd3, 8'h20);
      desel();
      chk("R6 write accepted after busy", st_we, 2'b10);
      drain();
   endtask

   task automatic t_extra_bit();
      sel();
      arm(2'd0, 1'b0, 2'd0, 8'h99);
      extra_bit = 1'b1;
      @(negedge clk);
      extra_bit = 1'b0;
      desel();
      chk("R10 trailing bit discards write", st_we, 0);
      chk("R10 no busy", busy, 0);
   endtask

   task automatic t_reserved();
      sel();
      arm(2'd3, 1'b0, 2'd0, 8'h55);
      desel();
      chk("R13 reserved kind ignored", st_we, 0);
      chk("R13 no busy", busy, 0);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; tick_en = 1'b0; req_valid = 1'b0;
      extra_bit = 1'b0; req_kind = 2'd0; req_chan = 1'b0; req_idx = 2'd0;
      req_data = 8'h00; wiper_flat = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_write();
      t_unselected_req();
      t_single_xfer();
      t_global_xfer();
      t_wp_block();
      t_wp_cancel();
      t_wp_after_commit();
      t_busy_ignore();
      t_extra_bit();
      t_reserved();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule